// File: doc/BRIEF.md
# Reference Voltage Window Trainer

This block steps one memory device through its input reference voltage search. Once impedance calibration has finished and a start pulse arrives, it turns on the device's reference training mode. It then visits every candidate reference code in turn. For each candidate it issues a mode-register write carrying the code, then asks an external engine to write a known pattern and read it back through the multi-purpose register path. That engine answers pass or fail. The block itself contains neither the data path nor the pattern generator.

The device offers two reference ranges of equal width in the same step size. One range sits higher than the other and the two overlap. The trainer places both on a single ascending scale counted in steps. The lower range supplies the points below the overlap, and the upper range supplies the overlap and everything above it. During the sweep the block keeps track of the longest contiguous run of passing points. When the sweep ends it programs the centre of that run with training mode still on. It then repeats the same value with training mode off, and raises done. If no point passes, it raises a fail flag and programs the mid-scale point instead.

Top module: `vref_window_trainer`

## Requirements
- R1: While reset is held and directly after it, mr_req, test_req, done and fail are all low.
- R2: start has no effect while zq_done is low. No mode-register request is made and done stays low.
- R3: Candidate writes cover scale points 0 to TOTAL-1 in ascending order. A point p below OFFSET is sent as mr_data = {1, 1, p}, meaning bit 7 is the training enable, bit 6 high selects the lower range, and bits 5:0 hold the step. A point p at or above OFFSET is sent as {1, 0, p-OFFSET}. With the defaults, OFFSET=23 and TOTAL=74.
- R4: Each candidate write is acknowledged before its single test request is made. No further mode-register write is issued until that test has returned its result.
- R5: The chosen point belongs to the longest contiguous run of passing points. When two runs are equally long, the run at the lower voltage wins.
- R6: The chosen point is start + floor((length-1)/2) of the winning run. This rounds down when the run length is even. The point is shown on result_idx.
- R7: When no point passes, fail is high at done and the programmed point is TOTAL/2 (37 with the defaults).
- R8: After the sweep there are exactly two writes. The first carries the chosen point with bit 7 set, the second carries the same point with bit 7 clear. done rises only after the second write has been acknowledged.
- R9: mr_req stays high and mr_data stays unchanged until mr_ack arrives.
- R10: A new start given after done, with zq_done high, clears done and fail and runs a fresh sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zq_done | input | 1 | Impedance calibration has completed |
| start | input | 1 | Pulse that begins a training run |
| mr_req | output | 1 | Mode-register write request |
| mr_data | output | 8 | Payload {train enable, lower-range select, step[5:0]} |
| mr_ack | input | 1 | One-cycle acknowledge of mr_req |
| test_req | output | 1 | Request a pattern write and readback |
| test_done | input | 1 | One-cycle strobe: the test result is valid |
| test_pass | input | 1 | Test result, sampled together with test_done |
| done | output | 1 | Training finished, with the final value written |
| fail | output | 1 | No candidate passed |
| result_idx | output | 7 | Chosen point on the unified scale |

## Verification
Two situations are hard to reach by chance: two passing runs of exactly the same length, and a run that touches either end of the unified scale. Random pass vectors almost never produce either. For that reason the stimulus places directed vectors for them (tied runs, even-length runs, a single pass at point 0 and at the top point, all pass, none pass) alongside random multi-run vectors with noise. The responder adds a random delay of zero to two cycles on both handshakes, so the payload hold and the write/test ordering are exercised under stretched waits.

// File: rtl/vref_train_pkg.sv
// Package: shared defaults and the sequencer state type for the reference
// voltage window trainer. Assumes nothing beyond IEEE 1800-2017.
package vref_train_pkg;

    localparam int DEF_STEPS  = 51;  // points per range (0..50)
    localparam int DEF_OFFSET = 23;  // upper range base, counted in steps above lower base
    localparam int DEF_CODE_W = 6;   // step field width in the mode-register payload

    typedef enum logic [2:0] {
        S_IDLE,
        S_CAND_MR,
        S_CAND_TEST,
        S_SET,
        S_EXIT,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/vref_code_map.sv
// Module: turns a point on the unified scale into a range select and a step
// code. Points below OFFSET use the lower range. All other points use the
// upper range, so points inside the overlap always come from the upper range.
// Assumes idx < OFFSET + STEPS.
module vref_code_map #(
    parameter int STEPS  = vref_train_pkg::DEF_STEPS,
    parameter int OFFSET = vref_train_pkg::DEF_OFFSET,
    parameter int IDX_W  = 7,
    parameter int CODE_W = vref_train_pkg::DEF_CODE_W
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              lo_range,
    output logic [CODE_W-1:0] code
);
    localparam logic [IDX_W-1:0] OFF_L = IDX_W'(OFFSET);

    logic [IDX_W-1:0] step_raw;

    // Purpose: choose the range and remove the base offset of the upper range.
    always_comb begin
        lo_range = (idx < OFF_L);
        step_raw = lo_range ? idx : (idx - OFF_L);
        code     = step_raw[CODE_W-1:0];
    end
endmodule

// File: rtl/vref_window_track.sv
// Module: follows the current run of passing points and keeps the longest
// run seen so far. Only a strictly longer run replaces the stored one, so on
// a tie the earlier (lower-voltage) run is kept. The centre is rounded down.
// Assumes points arrive in ascending order, one upd pulse per point.
module vref_window_track #(
    parameter int IDX_W = 7,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             pass,
    input  logic [IDX_W-1:0] idx,
    output logic [LEN_W-1:0] best_len,
    output logic [IDX_W-1:0] center
);
    logic [IDX_W-1:0] cur_start, best_start;
    logic [LEN_W-1:0] cur_len, nxt_len;
    logic [IDX_W-1:0] run_start;
    logic [LEN_W-1:0] half_len;

    // Purpose: work out the run length and start if this point passes.
    always_comb begin
        nxt_len   = cur_len + LEN_W'(1);
        run_start = (cur_len == '0) ? idx : cur_start;
        half_len  = (best_len - LEN_W'(1)) >> 1;
        center    = best_start + IDX_W'(half_len);
    end

    // Purpose: update the current run and the best run for each point.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (upd) begin
            if (pass) begin
                cur_len   <= nxt_len;
                cur_start <= run_start;
                if (nxt_len > best_len) begin
                    best_len   <= nxt_len;
                    best_start <= run_start;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end

    // R5: the stored best run never shrinks during a sweep.
    a_r5_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_len >= $past(best_len));

    // R5: the current run can never be longer than the stored best run.
    a_r5_cur_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cur_len <= best_len);
endmodule

// File: rtl/vref_seq_fsm.sv
// Module: controls the sweep. It waits for start while impedance calibration
// is complete, writes each candidate and runs its test, then writes the final
// point with training on and writes it again with training off.
// Assumes mr_ack and test_done are one-cycle strobes sent only while the
// matching request is high.
module vref_seq_fsm
    import vref_train_pkg::*;
#(
    parameter int TOTAL = 74,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zq_done,
    input  logic             mr_ack,
    input  logic             test_done,
    input  logic             no_pass,
    output logic             mr_req,
    output logic             mr_train,
    output logic             use_final,
    output logic [IDX_W-1:0] cand_idx,
    output logic             test_req,
    output logic             trk_clr,
    output logic             trk_upd,
    output logic             done,
    output logic             fail
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

    seq_state_t state;
    logic       go;

    // Purpose: decode request and status outputs from the state.
    always_comb begin
        go        = start && zq_done && (state == S_IDLE || state == S_DONE);
        mr_req    = (state == S_CAND_MR) || (state == S_SET) || (state == S_EXIT);
        mr_train  = (state != S_EXIT);
        use_final = (state == S_SET) || (state == S_EXIT);
        test_req  = (state == S_CAND_TEST);
        trk_clr   = go;
        trk_upd   = (state == S_CAND_TEST) && test_done;
        done      = (state == S_DONE);
    end

    // Purpose: advance the sweep and latch the fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cand_idx <= '0;
            fail     <= 1'b0;
        end else if (go) begin
            state    <= S_CAND_MR;
            cand_idx <= '0;
            fail     <= 1'b0;
        end else begin
            case (state)
                S_CAND_MR:   if (mr_ack) state <= S_CAND_TEST;
                S_CAND_TEST: if (test_done) begin
                    if (cand_idx == LAST) begin
                        state <= S_SET;
                    end else begin
                        cand_idx <= cand_idx + IDX_W'(1);
                        state    <= S_CAND_MR;
                    end
                end
                S_SET: if (mr_ack) begin
                    fail  <= no_pass;
                    state <= S_EXIT;
                end
                S_EXIT:  if (mr_ack) state <= S_DONE;
                default: ;
            endcase
        end
    end

    // R2: without completed calibration an idle sequencer stays idle.
    a_r2_zq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !zq_done) |=> state == S_IDLE);

    // R4: a test request only begins after a mode-register acknowledge.
    a_r4_test_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_req) |-> $past(mr_ack));
endmodule

// File: rtl/vref_window_trainer.sv
// Module: top level of the reference voltage window trainer. It connects the
// sequencer, the window tracker and the code map, builds the mode-register
// payload and picks the default mid-scale point when nothing passes.
// Assumes the test engine and the mode-register path sit outside this block.
module vref_window_trainer
    import vref_train_pkg::*;
#(
    parameter int STEPS  = DEF_STEPS,
    parameter int OFFSET = DEF_OFFSET,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        zq_done,
    input  logic        start,
    output logic        mr_req,
    output logic [7:0]  mr_data,
    input  logic        mr_ack,
    output logic        test_req,
    input  logic        test_done,
    input  logic        test_pass,
    output logic        done,
    output logic        fail,
    output logic [6:0]  result_idx
);
    localparam int TOTAL = OFFSET + STEPS;
    localparam int IDX_W = $clog2(TOTAL);
    localparam int LEN_W = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] MID = IDX_W'(TOTAL / 2);

    logic             mr_train, use_final, trk_clr, trk_upd, no_pass, lo_range;
    logic [IDX_W-1:0] cand_idx, center, map_idx, final_idx;
    logic [LEN_W-1:0] best_len;
    logic [CODE_W-1:0] code;

    vref_seq_fsm #(.TOTAL(TOTAL), .IDX_W(IDX_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .zq_done(zq_done),
        .mr_ack(mr_ack), .test_done(test_done), .no_pass(no_pass),
        .mr_req(mr_req), .mr_train(mr_train), .use_final(use_final),
        .cand_idx(cand_idx), .test_req(test_req), .trk_clr(trk_clr),
        .trk_upd(trk_upd), .done(done), .fail(fail)
    );

    vref_window_track #(.IDX_W(IDX_W), .LEN_W(LEN_W)) trk_i (
        .clk(clk), .rst_n(rst_n), .clr(trk_clr), .upd(trk_upd),
        .pass(test_pass), .idx(cand_idx), .best_len(best_len), .center(center)
    );

    vref_code_map #(.STEPS(STEPS), .OFFSET(OFFSET), .IDX_W(IDX_W), .CODE_W(CODE_W)) map_i (
        .idx(map_idx), .lo_range(lo_range), .code(code)
    );

    // Purpose: choose the final point and assemble the payload.
    always_comb begin
        no_pass    = (best_len == '0);
        final_idx  = no_pass ? MID : center;
        map_idx    = use_final ? final_idx : cand_idx;
        mr_data    = {mr_train, lo_range, code};
        result_idx = 7'(final_idx);
    end

    // R9: a pending request holds its payload until it is acknowledged.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_req && !mr_ack) |=> (mr_req && $stable(mr_data)));

    // R8: done rises only right after an acknowledged write with training off.
    a_r8_done_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mr_req && mr_ack && !mr_data[7]));

    // R7: a failed run reports the mid-scale point.
    a_r7_default_mid: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> result_idx == 7'(MID));

    // R4: a mode-register write and a test request are never both pending.
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mr_req && test_req));
endmodule

// File: tb/vref_window_trainer_tb_top.sv
// Bench: a responder model with random handshake delays, run over directed and
// random pass vectors. Every check compares the design against values that
// bench functions compute from the requirements.
module vref_window_trainer_tb_top;
    localparam int OFF   = 23;
    localparam int STEPS = 51;
    localparam int TOTAL = OFF + STEPS;
    localparam int MID   = TOTAL / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zq_done = 1'b0;
    logic       start = 1'b0;
    logic       mr_req;
    logic [7:0] mr_data;
    logic       mr_ack = 1'b0;
    logic       test_req;
    logic       test_done = 1'b0;
    logic       test_pass = 1'b0;
    logic       done;
    logic       fail;
    logic [6:0] result_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vref_window_trainer dut_i (
        .clk(clk), .rst_n(rst_n), .zq_done(zq_done), .start(start),
        .mr_req(mr_req), .mr_data(mr_data), .mr_ack(mr_ack),
        .test_req(test_req), .test_done(test_done), .test_pass(test_pass),
        .done(done), .fail(fail), .result_idx(result_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Payload of a candidate write, following R3.
    function automatic logic [7:0] enc(input int p);
        if (p < OFF) return {1'b1, 1'b1, 6'(p)};
        return {1'b1, 1'b0, 6'(p - OFF)};
    endfunction

    // Expected point from R5, R6, R7.
    function automatic int exp_point(input logic [TOTAL-1:0] v, output bit none);
        int cs = 0, cl = 0, bs = 0, bl = 0;
        for (int i = 0; i < TOTAL; i++) begin
            if (v[i]) begin
                if (cl == 0) cs = i;
                cl++;
                if (cl > bl) begin bl = cl; bs = cs; end
            end else begin
                cl = 0;
            end
        end
        none = (bl == 0);
        if (none) return MID;
        return bs + (bl - 1) / 2;
    endfunction

    task automatic run_case(input logic [TOTAL-1:0] v, input string tag);
        bit none, hold, pending;
        int ep, dly, n_wr, last_idx, cyc, r3err, r4err, r9err;
        logic [7:0] held, set_val, exit_val;
        ep = exp_point(v, none);
        hold = 0; pending = 0; dly = 0; n_wr = 0; last_idx = 0; cyc = 0;
        r3err = 0; r4err = 0; r9err = 0; set_val = '0; exit_val = '0; held = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !fail, "R10", {tag, " done/fail cleared on restart"},
            int'({done, fail}), 0);
        while (!done && cyc < 20000) begin
            mr_ack = 1'b0; test_done = 1'b0;
            if (mr_req) begin
                if (!hold) begin
                    hold = 1; held = mr_data; dly = $urandom_range(0, 2);
                end else if (mr_data != held) r9err++;
                if (dly == 0) begin
                    if (pending) r4err++;
                    if (n_wr < TOTAL) begin
                        if (held != enc(n_wr)) r3err++;
                        pending = 1; last_idx = n_wr;
                    end else if (n_wr == TOTAL) set_val = held;
                    else if (n_wr == TOTAL + 1) exit_val = held;
                    n_wr++;
                    mr_ack = 1'b1; hold = 0;
                end else dly--;
            end else if (test_req) begin
                if (!hold) begin hold = 1; dly = $urandom_range(0, 2); end
                if (dly == 0) begin
                    if (!pending) r4err++;
                    pending = 0;
                    test_done = 1'b1; test_pass = v[last_idx]; hold = 0;
                end else dly--;
            end
            @(negedge clk);
            cyc++;
        end
        mr_ack = 1'b0; test_done = 1'b0;
        chk(done == 1'b1, "R8", {tag, " done reached"}, int'(done), 1);
        chk(r3err == 0 && n_wr >= TOTAL, "R3", {tag, " candidate order errors"}, r3err, 0);
        chk(r4err == 0, "R4", {tag, " write/test ordering errors"}, r4err, 0);
        chk(r9err == 0, "R9", {tag, " payload changed while waiting"}, r9err, 0);
        chk(n_wr == TOTAL + 2, "R8", {tag, " total write count"}, n_wr, TOTAL + 2);
        chk(set_val == enc(ep), "R8", {tag, " final write, training on"},
            int'(set_val), int'(enc(ep)));
        chk(exit_val == {1'b0, enc(ep)[6:0]}, "R8", {tag, " final write, training off"},
            int'(exit_val), int'({1'b0, enc(ep)[6:0]}));
        chk(int'(result_idx) == ep, none ? "R7" : "R5", {tag, " chosen point (R6 rounding)"},
            int'(result_idx), ep);
        chk(fail == none, "R7", {tag, " fail flag"}, int'(fail), int'(none));
    endtask

    function automatic logic [TOTAL-1:0] runs_vec(input int s0, input int l0,
                                                  input int s1, input int l1);
        logic [TOTAL-1:0] v = '0;
        for (int i = 0; i < TOTAL; i++)
            if ((i >= s0 && i < s0 + l0) || (i >= s1 && i < s1 + l1)) v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs during reset and directly after it
        repeat (3) @(negedge clk);
        chk(!mr_req && !test_req && !done && !fail, "R1", "outputs in reset",
            int'({mr_req, test_req, done, fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mr_req && !test_req && !done && !fail, "R1", "outputs after reset",
            int'({mr_req, test_req, done, fail}), 0);
        // R2: start with calibration not complete
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!mr_req && !done, "R2", "start ignored without zq_done",
            int'({mr_req, done}), 0);
        zq_done = 1'b1;
        @(negedge clk);
        // Directed corner cases
        run_case('0, "none pass");                        // R7
        run_case('1, "all pass");                         // R6: 0 + 73/2 = 36
        run_case(runs_vec(5, 5, 40, 5), "tie");           // R5: expect 7
        run_case(runs_vec(10, 4, 0, 0), "even run");      // R6: expect 11
        run_case(runs_vec(TOTAL - 1, 1, 0, 0), "top only"); // R3 boundary
        run_case(runs_vec(0, 1, 0, 0), "bottom only");
        run_case(runs_vec(20, 6, 30, 7), "across overlap"); // R5: expect 33
        // Random vectors
        for (int k = 0; k < 8; k++) begin
            logic [TOTAL-1:0] v = '0;
            int nr = $urandom_range(1, 3);
            for (int r = 0; r < nr; r++) begin
                int s = $urandom_range(0, TOTAL - 1);
                int l = $urandom_range(1, 20);
                for (int i = s; i < s + l && i < TOTAL; i++) v[i] = 1'b1;
            end
            for (int n = 0; n < 3; n++) v[$urandom_range(0, TOTAL - 1)] = 1'b1;
            run_case(v, "random");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule